// File: doc/BRIEF.md
# Signed Iterative Divider with Word Register Interface

This peripheral divides a 32-bit signed dividend by a 16-bit signed divisor. Software writes the dividend into one word register and then writes the divisor into another. The divisor write is the only start command. The block then works for a fixed number of cycles and afterwards exposes a 32-bit quotient and a remainder. The remainder is 16 bits wide and is sign-extended to a full word. A status word carries a completion flag and a flag that marks a zero divisor.

The division truncates toward zero. The core works on operand magnitudes with a shift-and-subtract loop, one quotient bit per clock. A final cycle applies the signs. The quotient is negative when exactly one operand is negative, and the remainder follows the sign of the dividend. A zero divisor bypasses the loop and produces fixed result values at once. A new divisor write during a running division drops that division and starts over.

The control sequencer has three states:
- `S_IDLE`: results are valid.
- `S_RUN`: one shift-subtract step per cycle.
- `S_FIX`: sign correction and result capture.

Its transitions are:
- **launch**: IDLE→RUN on a non-zero divisor write.
- **step**: RUN→RUN while steps remain.
- **last**: RUN→FIX after the final step.
- **retire**: FIX→IDLE.
- **restart**: any state→RUN on a non-zero divisor write.
- **zero-out**: any state→IDLE on a zero divisor write.

A divisor write always takes priority over the normal transitions.

Top module: `sdiv_mmio`

## Requirements
- R1: Byte offsets select the registers: 0x00 is the dividend (read/write, 32 bits); 0x04 is the divisor (read/write; only bits [15:0] are kept, and reads return bits [31:16] as zero); 0x08 is the quotient; 0x0C is the remainder; 0x10 is status, with bit 0 = finish and bit 1 = zero-divisor flag. Any other offset reads as zero.
- R2: After reset the dividend, divisor, quotient and remainder read 0, and status reads 0x1 (finish set, zero-divisor flag clear).
- R3: A write to offset 0x04 with a non-zero divisor starts a division. Finish reads 0 from the clock edge that takes the write through the 32nd edge after it. On the 33rd edge after the write, the results update and finish returns to 1.
- R4: The quotient is the signed quotient truncated toward zero. Its sign is the XOR of the operand signs.
- R5: The remainder equals dividend minus quotient times divisor. It has the dividend's sign, sits in bits [15:0], and bits [31:16] are copies of bit 15.
- R6: Every divisor write sets the zero-divisor flag to 1 when the written bits [15:0] are zero, and clears it otherwise.
- R7: A zero divisor write leaves finish at 1 on the edge of the write. The same edge loads the quotient with 0xFFFFFFFF and the remainder with dividend bits [15:0], sign-extended.
- R8: A divisor write during a running division abandons it and starts over with the stored dividend and the new divisor. The full R3 timing is counted from the new write.
- R9: Writes to offsets 0x08, 0x0C and 0x10 change no register and start nothing.
- R10: Extreme operands wrap to 32 bits. -2147483648 / -1 gives quotient 0x80000000 and remainder 0. A divisor of -32768 is handled as magnitude 32768.
- R11: While a division runs, the quotient and remainder keep their previous values. A dividend write in that time does not alter the running result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | Byte offset of the accessed register |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |

## Verification
The hardest situation to reach from the ports is a second divisor write that lands while the loop is partway through its steps. The restart path and the zero-out path both depend on the state being RUN at that exact cycle. The bench reaches this by counting clock edges from the first divisor write. It issues the second write about ten edges later, well inside the 32-step window. It then times the finish flag against the second write, not the first. The same counted window is used to write a new dividend mid-run and show that the running result ignores it.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
    localparam int unsigned OFS_DIVIDEND = 'h00;
    localparam int unsigned OFS_DIVISOR  = 'h04;
    localparam int unsigned OFS_QUOT     = 'h08;
    localparam int unsigned OFS_REM      = 'h0C;
    localparam int unsigned OFS_STATUS   = 'h10;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FIX
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
module sdiv_core import sdiv_pkg::*; #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dvd,
    input  logic [DVS_W-1:0] dvs,
    output logic             finish,
    output logic [DVD_W-1:0] quo,
    output logic [DVS_W-1:0] rem
);
    localparam int REM_W = DVS_W + 1;
    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    sdiv_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [REM_W-1:0] acc_q;
    logic [DVD_W-1:0] sh_q;
    logic [REM_W-1:0] dvs_mag_q;
    logic             neg_quo_q, neg_rem_q;
    logic             finish_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;

    // operand magnitudes taken at launch
    logic             dvs_zero;
    logic [DVD_W-1:0] dvd_mag;
    logic [REM_W-1:0] dvs_ext, dvs_mag_in;
    assign dvs_zero   = (dvs == '0);
    assign dvd_mag    = dvd[DVD_W-1] ? (~dvd + 1'b1) : dvd;
    assign dvs_ext    = {dvs[DVS_W-1], dvs};
    assign dvs_mag_in = dvs_ext[REM_W-1] ? (~dvs_ext + 1'b1) : dvs_ext;

    // one restoring step
    logic [REM_W-1:0] shifted;
    logic [REM_W:0]   diff;
    logic             borrow;
    assign shifted = {acc_q[REM_W-2:0], sh_q[DVD_W-1]};
    assign diff    = {1'b0, shifted} - {1'b0, dvs_mag_q};
    assign borrow  = diff[REM_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch/restart, zero-out, step, last, retire
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = dvs_zero ? S_IDLE : S_RUN;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_RUN:  state_d = (cnt_q == LAST) ? S_FIX : S_RUN;
                S_FIX:  state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            sh_q      <= '0;
            dvs_mag_q <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            finish_q  <= 1'b1;
            quo_q     <= '0;
            rem_q     <= '0;
        end else if (start) begin
            if (dvs_zero) begin
                finish_q <= 1'b1;
                quo_q    <= '1;
                rem_q    <= dvd[DVS_W-1:0];
            end else begin
                finish_q  <= 1'b0;
                sh_q      <= dvd_mag;
                acc_q     <= '0;
                dvs_mag_q <= dvs_mag_in;
                cnt_q     <= '0;
                neg_quo_q <= dvd[DVD_W-1] ^ dvs[DVS_W-1];
                neg_rem_q <= dvd[DVD_W-1];
            end
        end else begin
            unique case (state_q)
                S_RUN: begin
                    sh_q  <= {sh_q[DVD_W-2:0], ~borrow};
                    acc_q <= borrow ? shifted : diff[REM_W-1:0];
                    cnt_q <= cnt_q + 1'b1;
                end
                S_FIX: begin
                    quo_q    <= neg_quo_q ? (~sh_q + 1'b1) : sh_q;
                    rem_q    <= neg_rem_q ? (~acc_q[DVS_W-1:0] + 1'b1)
                                          : acc_q[DVS_W-1:0];
                    finish_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign finish = finish_q;
    assign quo    = quo_q;
    assign rem    = rem_q;

    p_busy_clears_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> !finish_q);

    p_one_step_per_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !start) |=>
            (state_q == S_FIX || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    p_partial_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX) |-> (acc_q < dvs_mag_q));

    p_zero_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dvs_zero) |=> (finish_q && quo_q == '1 && state_q == S_IDLE));

    p_restart_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dvs_zero) |=> (state_q == S_RUN && cnt_q == '0 && !finish_q));
endmodule

// File: rtl/sdiv_regs.sv
`timescale 1ns/1ps
module sdiv_regs import sdiv_pkg::*; #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DVS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dvd,
    output logic [DVS_W-1:0]  dvs,
    output logic              start,
    input  logic              finish,
    input  logic [DATA_W-1:0] quo,
    input  logic [DATA_W-1:0] rem_ext
);
    localparam logic [ADDR_W-1:0] A_DVD  = ADDR_W'(OFS_DIVIDEND);
    localparam logic [ADDR_W-1:0] A_DVS  = ADDR_W'(OFS_DIVISOR);
    localparam logic [ADDR_W-1:0] A_QUO  = ADDR_W'(OFS_QUOT);
    localparam logic [ADDR_W-1:0] A_REM  = ADDR_W'(OFS_REM);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    logic [DATA_W-1:0] dvd_q;
    logic [DVS_W-1:0]  dvs_q;
    logic              zero_q;

    assign start = wr_en && (addr == A_DVS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_DVD) dvd_q <= wr_data;
            if (addr == A_DVS) begin
                dvs_q  <= wr_data[DVS_W-1:0];
                zero_q <= (wr_data[DVS_W-1:0] == '0);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_DVD)       rd_data = dvd_q;
        else if (addr == A_DVS)  rd_data = {{(DATA_W-DVS_W){1'b0}}, dvs_q};
        else if (addr == A_QUO)  rd_data = quo;
        else if (addr == A_REM)  rd_data = rem_ext;
        else if (addr == A_STAT) rd_data = {{(DATA_W-2){1'b0}}, zero_q, finish};
    end

    assign dvd = dvd_q;
    // the core samples the new divisor straight from the bus on the start edge
    assign dvs = start ? wr_data[DVS_W-1:0] : dvs_q;

    p_zero_flag_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (zero_q == ($past(wr_data[DVS_W-1:0]) == '0)));

    p_ro_write_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_QUO || addr == A_REM || addr == A_STAT)) |-> !start);
endmodule

// File: rtl/sdiv_mmio.sv
`timescale 1ns/1ps
module sdiv_mmio #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DVS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] dvd;
    logic [DVS_W-1:0]  dvs;
    logic              start, finish;
    logic [DATA_W-1:0] quo;
    logic [DVS_W-1:0]  rem;
    logic [DATA_W-1:0] rem_ext;

    assign rem_ext = {{(DATA_W-DVS_W){rem[DVS_W-1]}}, rem};

    sdiv_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DVS_W(DVS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .dvd(dvd), .dvs(dvs),
        .start(start), .finish(finish), .quo(quo), .rem_ext(rem_ext)
    );

    sdiv_core #(.DVD_W(DATA_W), .DVS_W(DVS_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .dvd(dvd), .dvs(dvs),
        .finish(finish), .quo(quo), .rem(rem)
    );
endmodule

// File: tb/tb_sdiv_mmio.sv
`timescale 1ns/1ps
module tb_sdiv_mmio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdiv_mmio dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                   .wr_data(wr_data), .rd_data(rd_data));

    localparam logic [4:0] A_DVD = 5'h00, A_DVS = 5'h04, A_QUO = 5'h08,
                           A_REM = 5'h0C, A_STAT = 5'h10;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic model(input logic [31:0] a, input logic [15:0] b,
                         output logic [31:0] q, output logic [31:0] r);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = 32'(sa / sb);
        r = 32'(sa % sb);
    endtask

    // full division with finish timing, results and status
    task automatic run_div(input logic [31:0] a, input logic [15:0] b, input string req);
        logic [31:0] v, q, r;
        model(a, b, q, r);
        wr(A_DVD, a);
        wr(A_DVS, {16'h0, b});
        rd(A_STAT, v); check("R3", "finish low at start", v, 32'h0);
        repeat (32) @(negedge clk);
        rd(A_STAT, v); check("R3", "finish low after 32 edges", v, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R3", "finish high after 33 edges", v, 32'h1);
        rd(A_QUO, v);  check(req, "quotient", v, q);
        rd(A_REM, v);  check(req, "remainder", v, r);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_DVD, v);  check("R2", "dividend reset", v, 0);
        rd(A_DVS, v);  check("R2", "divisor reset", v, 0);
        rd(A_QUO, v);  check("R2", "quotient reset", v, 0);
        rd(A_REM, v);  check("R2", "remainder reset", v, 0);
        rd(A_STAT, v); check("R2", "status reset", v, 32'h1);
    endtask

    task automatic t_signs;
        run_div(32'd100, 16'd7, "R4");
        run_div(-32'sd100, 16'd7, "R5");
        run_div(32'd100, -16'sd7, "R4");
        run_div(-32'sd100, -16'sd7, "R5");
        run_div(32'd5, 16'd10, "R4");
        run_div(32'd12345678, 16'd32767, "R5");
    endtask

    task automatic t_extremes;
        run_div(32'h8000_0000, 16'hFFFF, "R10");
        run_div(32'h7FFF_FFFF, 16'h8000, "R10");
        run_div(32'h8000_0001, 16'h8000, "R10");
        run_div(32'h7FFF_FFFF, 16'd1, "R10");
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(A_DVD, 32'hA5A5_1234);
        rd(A_DVD, v); check("R1", "dividend readback", v, 32'hA5A5_1234);
        wr(A_DVS, 32'hABCD_8001);
        rd(A_DVS, v); check("R1", "divisor upper bits zero", v, 32'h0000_8001);
        rd(5'h14, v); check("R1", "unmapped offset", v, 32'h0);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_div0;
        logic [31:0] v;
        wr(A_DVD, 32'h1234_8765);
        wr(A_DVS, 32'hFFFF_0000);
        rd(A_STAT, v); check("R7", "status on zero divisor", v, 32'h3);
        rd(A_QUO, v);  check("R7", "quotient on zero divisor", v, 32'hFFFF_FFFF);
        rd(A_REM, v);  check("R7", "remainder on zero divisor", v, 32'hFFFF_8765);
        wr(A_DVD, 32'hFFFF_1234);
        wr(A_DVS, 32'h0);
        rd(A_REM, v);  check("R7", "positive low half", v, 32'h0000_1234);
        rd(A_STAT, v); check("R6", "zero flag set", v, 32'h3);
        run_div(32'd9, 16'd3, "R6");
        rd(A_STAT, v); check("R6", "zero flag cleared", v, 32'h1);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        wr(A_DVD, 32'd1000);
        wr(A_DVS, 32'd3);
        repeat (10) @(negedge clk);
        wr(A_DVS, {16'h0, -16'sd7});
        repeat (32) @(negedge clk);
        rd(A_STAT, v); check("R8", "still busy after restart", v, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R8", "done 33 edges after restart", v, 32'h1);
        rd(A_QUO, v);  check("R8", "restarted quotient", v, -32'sd142);
        rd(A_REM, v);  check("R8", "restarted remainder", v, 32'd6);
        wr(A_DVS, 32'd3);
        repeat (5) @(negedge clk);
        wr(A_DVS, 32'd0);
        rd(A_STAT, v); check("R8", "zero write mid-run completes", v, 32'h3);
        rd(A_QUO, v);  check("R8", "zero write mid-run quotient", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        run_div(32'd77, 16'd5, "R4");
        wr(A_DVS, 32'd4);
        repeat (5) @(negedge clk);
        wr(A_DVD, 32'd1_000_000);
        rd(A_QUO, v); check("R11", "quotient held mid-run", v, 32'd15);
        rd(A_REM, v); check("R11", "remainder held mid-run", v, 32'd2);
        repeat (40) @(negedge clk);
        rd(A_QUO, v); check("R11", "dividend write ignored by run", v, 32'd19);
        rd(A_REM, v); check("R11", "remainder of original", v, 32'd1);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        wr(A_QUO, 32'hDEAD_BEEF);
        wr(A_REM, 32'hCAFE_F00D);
        wr(A_STAT, 32'h0);
        rd(A_QUO, v);  check("R9", "quotient unchanged", v, 32'd19);
        rd(A_REM, v);  check("R9", "remainder unchanged", v, 32'd1);
        rd(A_STAT, v); check("R9", "status unchanged, no start", v, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_signs();
        t_extremes();
        t_div0();
        t_restart();
        t_hold();
        t_readonly();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule